// File: doc/BRIEF.md
# Edge-Triggered External Event Controller

This block collects a set of asynchronous external event lines, grouped in banks of 32, and turns them into one interrupt output per line. Every line is brought into the clock domain through a two-stage synchronizer. Lines flagged as configurable in a fixed build-time bitmap get an edge detector with independent rising and falling enables. Each of these lines latches its rising and falling events in two separate pending flags, and software clears a flag by writing a 1 to it. Lines without that flag carry their synchronized level directly to the mask stage. Each line's interrupt passes through a per-line mask before reaching its registered output.

Software reaches the block through a simple 32-bit register port with a byte address. Each bus access also carries a secure flag and a privileged flag. Each line carries secure and privileged attribute bits. A master that lacks a required attribute can neither see nor change that line's bits. A sticky global lock freezes the attribute registers and the per-line compartment words. The block also holds four general port-selection words and a read-only word that describes its build parameters. Reads return their data one cycle after the read strobe.

Top module: `evc_top`

## Requirements
- R1: After synchronous reset every writable register reads 0, the lock flag is clear and all interrupt outputs are low.
- R2: Bank b occupies 0x20*b. Within a bank, the rising-enable word is at offset 0x00, the falling-enable word at 0x04, rising pending at 0x0C, falling pending at 0x10, the secure attribute at 0x14 and the privileged attribute at 0x18. The mask of bank b is at 0x080+0x10*b. The configurable bitmap of bank b reads at 0x3EC-4*b. Address 0x3F0 reads {4'b0, compartment-ID width[27:24], 12'b0, CPU count-1[11:8], event count-1[7:0]}. Bit i of a per-bank word belongs to line 32*b+i.
- R3: On a configurable line, a synchronized 0-to-1 transition sets the rising pending flag when the rising enable is 1. A 1-to-0 transition sets the falling pending flag when the falling enable is 1. With both enables set, both edges are recorded, each in its own flag.
- R4: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R5: The registered interrupt output of a configurable line is high when its mask bit is 1 and either of its pending flags is set. A line with mask bit 0 never asserts.
- R6: On a non-configurable line the interrupt output follows the synchronized input level ANDed with its mask bit. Its trigger-enable and pending bits always read 0, and writes to them are ignored.
- R7: The four port-selection words at 0x060+4*n are plain 32-bit read/write registers. The compartment word of event e at 0x180+4*e keeps only bit 0 (enable) and bits 6:4 (static ID), and all other bits read 0.
- R8: Writing 1 to bit 0 of 0x070 sets the lock flag, and it stays set until reset. While it is set, writes to the secure attribute, privileged attribute and compartment words are ignored.
- R9: When a bus access has its secure flag at 0 and the line's secure attribute is 1, that line's bits are left unchanged by the write and read as 0. The same holds when the privileged flag is 0 and the privileged attribute is 1. This applies to every per-line register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 96 | Asynchronous external event lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Access is from a secure master |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | 96 | Per-line registered interrupt outputs |

## Verification
Some properties are checked on every cycle:
- an edge seen by a detector is always in its pending flag one cycle later, even when a clear arrives in the same cycle;
- no interrupt rises on a line whose mask was 0;
- the lock never falls, and the attribute words do not move while it is set;
- a non-secure write never changes a trigger-enable bit of a secure line.

The address decode, the hardware description words and the compartment field packing can only be shown by the bench's scenarios, which read values back through the port. The same applies to read masking for restricted masters and to the pass-through of non-configurable lines. Randomly chosen enable, mask and input patterns are compared against a model of the pending flags.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // offsets inside one bank window
  localparam logic [4:0] OFS_RISE_EN = 5'h00;
  localparam logic [4:0] OFS_FALL_EN = 5'h04;
  localparam logic [4:0] OFS_RISE_PD = 5'h0C;
  localparam logic [4:0] OFS_FALL_PD = 5'h10;
  localparam logic [4:0] OFS_SECURE  = 5'h14;
  localparam logic [4:0] OFS_PRIVIL  = 5'h18;
  // global addresses
  localparam int BANK_STRIDE = 'h20;
  localparam int A_PORTSEL   = 'h060;
  localparam int A_LOCK      = 'h070;
  localparam int A_MASK      = 'h080;
  localparam int MASK_STRIDE = 'h10;
  localparam int A_CID       = 'h180;
  localparam int A_CFGMAP    = 'h3EC;
  localparam int A_HWDESC    = 'h3F0;
  localparam int N_PORTSEL   = 4;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= async_i;
      st2_q <= st1_q;
    end
  end

  assign sync_o = st2_q;
endmodule

// File: rtl/evc_bank.sv
module evc_bank #(
  parameter int               LPB = 32,
  parameter logic [LPB-1:0]   CFG = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LPB-1:0] lvl_i,
  input  logic [LPB-1:0] rise_en_i,
  input  logic [LPB-1:0] fall_en_i,
  input  logic [LPB-1:0] rise_clr_i,
  input  logic [LPB-1:0] fall_clr_i,
  output logic [LPB-1:0] rise_pd_o,
  output logic [LPB-1:0] fall_pd_o
);
  logic [LPB-1:0] prev_q, rise_evt, fall_evt, rpd_q, fpd_q;

  // edge detector only on lines the build marks configurable
  for (genvar i = 0; i < LPB; i++) begin : g_line
    if (CFG[i]) begin : g_edge
      assign rise_evt[i] = lvl_i[i] & ~prev_q[i] & rise_en_i[i];
      assign fall_evt[i] = ~lvl_i[i] & prev_q[i] & fall_en_i[i];
    end else begin : g_plain
      assign rise_evt[i] = 1'b0;
      assign fall_evt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      rpd_q  <= '0;
      fpd_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      rpd_q  <= ((rpd_q & ~rise_clr_i) | rise_evt) & CFG;
      fpd_q  <= ((fpd_q & ~fall_clr_i) | fall_evt) & CFG;
    end
  end

  assign rise_pd_o = rpd_q;
  assign fall_pd_o = fpd_q;

  // R3 / R4: a detected edge is always latched, even against a clear
  p_rise_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_evt != '0) |=> ((rise_pd_o & $past(rise_evt)) == $past(rise_evt)));
  p_fall_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (fall_evt != '0) |=> ((fall_pd_o & $past(fall_evt)) == $past(fall_evt)));
endmodule

// File: rtl/evc_top.sv
module evc_top #(
  parameter int NBANK = 3,
  parameter int LPB   = 32,
  parameter int NCPU  = 2,
  parameter int CID_W = 3,
  parameter logic [NBANK*LPB-1:0] CFG_MAP = {32'h00FF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0FFF}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NBANK*LPB-1:0] ev_i,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [9:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_sec,
  input  logic                 bus_priv,
  output logic [31:0]          bus_rdata,
  output logic [NBANK*LPB-1:0] irq_o
);
  import evc_pkg::*;

  localparam int NEV = NBANK * LPB;
  localparam int CIW = $clog2(NEV);
  localparam logic [31:0] HWDESC = {4'd0, 4'(CID_W), 12'd0, 4'(NCPU - 1), 8'(NEV - 1)};

  typedef logic [NBANK-1:0][LPB-1:0] bankvec_t;

  bankvec_t rise_en_q, fall_en_q, sec_q, priv_q, mask_q;
  bankvec_t rise_clr, fall_clr, rise_pd, fall_pd, allow, cfg_v, lvl_v, irq_d;
  logic [NEV-1:0] sync_w, allow_flat;
  logic [31:0]    portsel_q [N_PORTSEL];
  logic [3:0]     cid_q [NEV];
  logic           lock_q;
  logic [31:0]    rd_d, rdata_q;
  logic [NEV-1:0] irq_q;
  logic           cid_hit;
  logic [CIW-1:0] cid_idx;

  assign cfg_v      = CFG_MAP;
  assign lvl_v      = sync_w;
  assign allow_flat = allow;

  evc_sync #(.W(NEV)) u_sync (
    .clk(clk), .rst(rst), .async_i(ev_i), .sync_o(sync_w)
  );

  // write filter per line from the requester's attributes
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      allow[b] = ~(({LPB{~bus_sec}} & sec_q[b]) | ({LPB{~bus_priv}} & priv_q[b]));
      rise_clr[b] = (bus_wr && int'(bus_addr) == b*BANK_STRIDE + int'(OFS_RISE_PD))
                    ? bus_wdata & allow[b] : '0;
      fall_clr[b] = (bus_wr && int'(bus_addr) == b*BANK_STRIDE + int'(OFS_FALL_PD))
                    ? bus_wdata & allow[b] : '0;
    end
  end

  assign cid_hit = int'(bus_addr) >= A_CID && int'(bus_addr) < A_CID + 4*NEV
                   && bus_addr[1:0] == 2'b00;
  assign cid_idx = CIW'((int'(bus_addr) - A_CID) / 4);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    evc_bank #(.LPB(LPB), .CFG(CFG_MAP[b*LPB +: LPB])) u_bank (
      .clk(clk), .rst(rst), .lvl_i(lvl_v[b]),
      .rise_en_i(rise_en_q[b]), .fall_en_i(fall_en_q[b]),
      .rise_clr_i(rise_clr[b]), .fall_clr_i(fall_clr[b]),
      .rise_pd_o(rise_pd[b]), .fall_pd_o(fall_pd[b])
    );
    assign irq_d[b] = (((rise_pd[b] | fall_pd[b]) & cfg_v[b]) | (lvl_v[b] & ~cfg_v[b])) & mask_q[b];
  end

  function automatic logic [LPB-1:0] merge(input logic [LPB-1:0] old, wr, ok);
    return (old & ~ok) | (wr & ok);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      sec_q     <= '0;
      priv_q    <= '0;
      mask_q    <= '0;
      lock_q    <= 1'b0;
      for (int n = 0; n < N_PORTSEL; n++) portsel_q[n] <= '0;
      for (int e = 0; e < NEV; e++) cid_q[e] <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_RISE_EN))
          rise_en_q[b] <= merge(rise_en_q[b], bus_wdata, allow[b]) & cfg_v[b];
        if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_FALL_EN))
          fall_en_q[b] <= merge(fall_en_q[b], bus_wdata, allow[b]) & cfg_v[b];
        if (!lock_q && int'(bus_addr) == b*BANK_STRIDE + int'(OFS_SECURE))
          sec_q[b] <= merge(sec_q[b], bus_wdata, allow[b]);
        if (!lock_q && int'(bus_addr) == b*BANK_STRIDE + int'(OFS_PRIVIL))
          priv_q[b] <= merge(priv_q[b], bus_wdata, allow[b]);
        if (int'(bus_addr) == A_MASK + b*MASK_STRIDE)
          mask_q[b] <= merge(mask_q[b], bus_wdata, allow[b]);
      end
      for (int n = 0; n < N_PORTSEL; n++)
        if (int'(bus_addr) == A_PORTSEL + 4*n) portsel_q[n] <= bus_wdata;
      if (int'(bus_addr) == A_LOCK && bus_wdata[0]) lock_q <= 1'b1;
      if (cid_hit && !lock_q && allow_flat[cid_idx])
        cid_q[cid_idx] <= {bus_wdata[6:4], bus_wdata[0]};
    end
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_RISE_EN)) rd_d = rise_en_q[b] & allow[b];
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_FALL_EN)) rd_d = fall_en_q[b] & allow[b];
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_RISE_PD)) rd_d = rise_pd[b] & allow[b];
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_FALL_PD)) rd_d = fall_pd[b] & allow[b];
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_SECURE))  rd_d = sec_q[b] & allow[b];
      if (int'(bus_addr) == b*BANK_STRIDE + int'(OFS_PRIVIL))  rd_d = priv_q[b] & allow[b];
      if (int'(bus_addr) == A_MASK + b*MASK_STRIDE)            rd_d = mask_q[b] & allow[b];
      if (int'(bus_addr) == A_CFGMAP - 4*b)                    rd_d = cfg_v[b];
    end
    for (int n = 0; n < N_PORTSEL; n++)
      if (int'(bus_addr) == A_PORTSEL + 4*n) rd_d = portsel_q[n];
    if (int'(bus_addr) == A_LOCK)   rd_d = {31'd0, lock_q};
    if (int'(bus_addr) == A_HWDESC) rd_d = HWDESC;
    if (cid_hit && allow_flat[cid_idx])
      rd_d = {25'd0, cid_q[cid_idx][3:1], 3'd0, cid_q[cid_idx][0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      if (bus_rd) rdata_q <= rd_d;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst) lock_q |=> lock_q);
  p_lock_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(sec_q) && $stable(priv_q)));
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~$past(mask_q)) == '0);
  p_secure_filter_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_sec) |=> (((rise_en_q ^ $past(rise_en_q)) & $past(sec_q)) == '0));
endmodule

// File: tb/evc_top_tb.sv
module evc_top_tb;
  localparam int NEV = 96;

  logic            clk = 1'b0;
  logic            rst;
  logic [NEV-1:0]  ev_i;
  logic            bus_wr, bus_rd, bus_sec, bus_priv;
  logic [9:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NEV-1:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  evc_top u_dut (
    .clk(clk), .rst(rst), .ev_i(ev_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit s = 1, input bit p = 1);
    @(negedge clk);
    bus_wr = 1; bus_addr = 10'(a); bus_wdata = d; bus_sec = s; bus_priv = p;
    @(negedge clk);
    bus_wr = 0; bus_sec = 1; bus_priv = 1;
  endtask

  task automatic rd(input int a, output logic [31:0] d, input bit s = 1, input bit p = 1);
    @(negedge clk);
    bus_rd = 1; bus_addr = 10'(a); bus_sec = s; bus_priv = p;
    @(negedge clk);
    bus_rd = 0; bus_sec = 1; bus_priv = 1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_rise(input logic [31:0] en, v0, v1);
    return en & v1 & ~v0;
  endfunction
  function automatic logic [31:0] exp_fall(input logic [31:0] en, v0, v1);
    return en & ~v1 & v0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r_en, f_en, v0, v1, m;
    void'($urandom(32'd1234));
    rst = 1; ev_i = '0; bus_wr = 0; bus_rd = 0; bus_sec = 1; bus_priv = 1;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd('h000, d); check("R1 rise enable", d, 0);
    rd('h034, d); check("R1 secure attr", d, 0);
    rd('h080, d); check("R1 mask", d, 0);
    rd('h070, d); check("R1 lock", d, 0);
    check("R1 irq low", irq_o[31:0] | irq_o[63:32] | irq_o[95:64], 0);

    // R2 description words
    rd('h3F0, d); check("R2 hw description", d, {4'd0, 4'd3, 12'd0, 4'd1, 8'd95});
    rd('h3EC, d); check("R2 bitmap bank0", d, 32'hFFFF_0FFF);
    rd('h3E4, d); check("R2 bitmap bank2", d, 32'h00FF_FFFF);

    // R3 both edges on line 0
    wr('h000, 32'h1); wr('h004, 32'h1); wr('h080, 32'h1);
    ev_i[0] = 1; settle();
    rd('h00C, d); check("R3 rising latched", d, 1);
    rd('h010, d); check("R3 falling not yet", d, 0);
    check("R5 irq with mask", 32'(irq_o[0]), 1);
    ev_i[0] = 0; settle();
    rd('h010, d); check("R3 falling latched", d, 1);

    // R4 clear rising only
    wr('h00C, 32'h1); settle();
    rd('h00C, d); check("R4 rising cleared", d, 0);
    rd('h010, d); check("R4 falling kept", d, 1);
    wr('h010, 32'h1); settle();
    check("R5 irq drops with no pending", 32'(irq_o[0]), 0);

    // R4 clear in same cycle as a new rising edge
    @(negedge clk); ev_i[0] = 1; settle();
    ev_i[0] = 0; settle();
    @(negedge clk); ev_i[0] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_wr = 1; bus_addr = 10'h00C; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 0;
    settle();
    rd('h00C, d); check("R4 edge beats clear", d, 1);

    // R5 mask off
    wr('h080, 32'h0); settle();
    check("R5 masked line quiet", 32'(irq_o[0]), 0);

    // R6 non-configurable line 12
    wr('h000, 32'h0000_1000); rd('h000, d); check("R6 trigger write ignored", d, 0);
    wr('h080, 32'h0000_1000);
    ev_i[12] = 1; settle();
    check("R6 level passes", 32'(irq_o[12]), 1);
    rd('h00C, d); check("R6 no pending bit", d & 32'h0000_1000, 0);
    ev_i[12] = 0; settle();
    check("R6 level low", 32'(irq_o[12]), 0);

    // R7 port selection and compartment words
    wr('h068, 32'hA5A5_1234); rd('h068, d); check("R7 port select", d, 32'hA5A5_1234);
    wr('h180 + 4*40, 32'hFFFF_FFFF); rd('h180 + 4*40, d); check("R7 compartment fields", d, 32'h71);

    // R9 secure attribute on line 3 of bank 0
    wr('h014, 32'h8);
    wr('h000, 32'hFFFF_FFFF, 0, 1);
    rd('h000, d); check("R9 secure bit kept", d & 32'h8, 0);
    rd('h000, d); check("R9 other bits written", d, 32'hFFFF_0FF7);
    rd('h014, d, 0, 1); check("R9 secure read masked", d, 0);
    wr('h038, 32'h4);
    wr('h024, 32'hFFFF_FFFF, 1, 0);
    rd('h024, d); check("R9 privileged bit kept", d & 32'h4, 0);
    rd('h024, d, 1, 0); check("R9 privileged read masked", d & 32'h4, 0);

    // R3/R4/R5 random patterns on bank 1
    v0 = '0;
    for (int it = 0; it < 24; it++) begin
      r_en = $urandom; f_en = $urandom; m = $urandom; v1 = $urandom;
      wr('h020, r_en); wr('h024, f_en); wr('h090, m);
      wr('h02C, 32'hFFFF_FFFF); wr('h030, 32'hFFFF_FFFF);
      ev_i[63:32] = v1; settle();
      rd('h02C, d); check("R3 random rising", d, exp_rise(r_en, v0, v1));
      rd('h030, d); check("R3 random falling", d, exp_fall(f_en, v0, v1));
      check("R5 random irq", irq_o[63:32], (exp_rise(r_en, v0, v1) | exp_fall(f_en, v0, v1)) & m);
      v0 = v1;
    end

    // R8 lock
    wr('h070, 32'h1);
    wr('h014, 32'hFFFF_FFFF); rd('h014, d); check("R8 secure frozen", d, 32'h8);
    wr('h058, 32'hFFFF_FFFF); rd('h058, d); check("R8 privileged frozen", d, 0);
    wr('h180 + 4*40, 32'h0); rd('h180 + 4*40, d); check("R8 compartment frozen", d, 32'h71);
    wr('h070, 32'h0); rd('h070, d); check("R8 lock sticky", d, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule